// File: doc/BRIEF.md
# Debug Port Protocol Mode Selector

This block watches the single mode/data line of a debug port that can speak either JTAG or the two-wire serial debug protocol (SWD). It samples the line on every rising edge of the debug clock and holds a one-bit mode output: 0 selects JTAG, 1 selects SWD. Downstream logic uses that bit to choose which protocol engine owns the pins.

A mode change is honoured only when a 16-bit switch word, received least significant bit first, directly follows a run of at least 50 consecutive high samples. The word 0xE79E moves the port from JTAG to SWD, and the word 0xE73C moves it from SWD back to JTAG. The same run counter also drives a one-cycle line-reset pulse for the serial engine whenever the port is in SWD mode.

The capture window opens when the run reaches 50. The first low sample after that run is bit 0 of the word. The window closes after 16 bits, whether or not they matched.

Top module: `swjModeSelect`

## Requirements
- R1: While the asynchronous reset is asserted, and in the first cycle after it is released, swdMode is 0 (JTAG) and modeChange and lineReset are 0. Asserting reset at any time returns swdMode to 0 at once.
- R2: In JTAG mode, a run of at least 50 high samples followed by the 16 bits of 0xE79E (bit 0 first) sets swdMode to 1. modeChange is 1 in the cycle after the last bit is sampled.
- R3: A run of only 49 high samples in front of a valid switch word causes no mode change.
- R4: In SWD mode, a run of at least 50 high samples followed by 0xE73C (bit 0 first) sets swdMode to 0, with a modeChange pulse timed as in R2.
- R5: A 16-bit word that does not match the word for the opposite mode causes no mode change. It also closes the window, so a valid word that follows it with no new run is ignored.
- R6: In SWD mode, lineReset is 1 for exactly one cycle. That cycle comes directly after the 50th consecutive high sample. Continued high samples do not pulse it again.
- R7: In JTAG mode, lineReset stays 0 during runs of any length.
- R8: A low sample clears the run count, so two runs of 30 high samples separated by one low sample do not enable a switch.
- R9: modeChange lasts exactly one cycle, and swdMode never changes without it. The switch word for the current mode (0xE79E while in SWD) leaves the mode unchanged and produces no pulse.
- R10: The run counter saturates at 63. Runs of 100 or more high samples still enable a switch and produce only one line-reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock; the line is sampled on rising edges |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| lineIn | input | 1 | Sampled value of the shared mode/data line |
| swdMode | output | 1 | 0 = JTAG selected, 1 = SWD selected |
| modeChange | output | 1 | One-cycle pulse after an accepted switch word |
| lineReset | output | 1 | One-cycle pulse when a 50-sample high run completes in SWD mode |

## Verification
The in-RTL assertions check several properties on every cycle:
- a low sample clears the run counter, and the counter holds at saturation;
- a mode flip is always accompanied by a modeChange pulse;
- both pulses last exactly one cycle;
- lineReset never appears in JTAG mode;
- the window closes after every completed word.

Whether the right word after the right run length actually switches the mode can only be shown by bench scenarios. The same holds for the exact 49/50 boundary, for the rejection of a valid word after a mismatch or a broken run, and for the reset values.

// File: rtl/swjSelPkg.sv
package swjSelPkg;
  typedef struct packed {
    logic shiftBit;   // capture the sampled bit into the word register
    logic dropBits;   // window finished: clear word register and bit count
  } dpStrobes_t;
endpackage

// File: rtl/swjLineDatapath.sv
module swjLineDatapath
  import swjSelPkg::*;
#(
  parameter int RUN_MIN = 50,
  parameter int CNT_W   = 6,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  dpStrobes_t        strobes,
  output logic              runHit,
  output logic              wordFull,
  output logic [WORD_W-1:0] nextWord
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int BIT_W   = $clog2(WORD_W);

  logic [CNT_W-1:0]  highCnt;
  logic [WORD_W-1:0] shiftReg;
  logic [BIT_W-1:0]  bitCnt;

  // run-length counter of consecutive high samples, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            highCnt <= '0;
    else if (!lineIn)                     highCnt <= '0;
    else if (highCnt != CNT_W'(CNT_MAX))  highCnt <= highCnt + CNT_W'(1);
  end

  // this sample completes a run of RUN_MIN highs
  assign runHit = lineIn && (highCnt == CNT_W'(RUN_MIN - 1));

  // LSB-first word: new bit enters at the top and moves down
  assign nextWord = {lineIn, shiftReg[WORD_W-1:1]};
  assign wordFull = (bitCnt == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.dropBits) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.shiftBit) begin
      shiftReg <= nextWord;
      bitCnt   <= bitCnt + BIT_W'(1);
    end
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineIn |=> highCnt == '0);

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineIn && highCnt == CNT_W'(CNT_MAX)) |=> highCnt == CNT_W'(CNT_MAX));
endmodule

// File: rtl/swjModeControl.sv
module swjModeControl
  import swjSelPkg::*;
#(
  parameter int              WORD_W  = 16,
  parameter logic [WORD_W-1:0] TO_SWD  = 16'hE79E,
  parameter logic [WORD_W-1:0] TO_JTAG = 16'hE73C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              runHit,
  input  logic              wordFull,
  input  logic [WORD_W-1:0] nextWord,
  output dpStrobes_t        strobes,
  output logic              swdMode,
  output logic              modeChange,
  output logic              lineReset
);
  logic armed;       // a qualifying high run has been seen
  logic collecting;  // word bits are being received
  logic capturing;
  logic wordDone;
  logic wordHit;
  logic [WORD_W-1:0] target;

  // first low after the run is bit 0 of the word
  assign capturing = armed && (collecting || !lineIn);
  assign wordDone  = capturing && wordFull;
  assign target    = swdMode ? TO_JTAG : TO_SWD;
  assign wordHit   = wordDone && (nextWord == target);

  assign strobes.shiftBit = capturing && !wordFull;
  assign strobes.dropBits = wordDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swdMode    <= 1'b0;
      modeChange <= 1'b0;
      lineReset  <= 1'b0;
      armed      <= 1'b0;
      collecting <= 1'b0;
    end else begin
      modeChange <= wordHit;
      lineReset  <= runHit && swdMode;
      if (wordHit) swdMode <= !swdMode;
      if (wordDone) begin
        armed      <= 1'b0;
        collecting <= 1'b0;
      end else begin
        if (capturing) collecting <= 1'b1;
        if (runHit)    armed      <= 1'b1;
      end
    end
  end

  // R9
  mode_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swdMode != $past(swdMode)) |-> modeChange);

  // R9
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> !modeChange);

  // R7
  lr_jtag_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineReset |-> swdMode);

  // R6
  lr_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineReset |=> !lineReset);

  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> !armed);
endmodule

// File: rtl/swjModeSelect.sv
module swjModeSelect
  import swjSelPkg::*;
#(
  parameter int RUN_MIN = 50,
  parameter int CNT_W   = 6,
  parameter int WORD_W  = 16,
  parameter logic [WORD_W-1:0] TO_SWD  = 16'hE79E,
  parameter logic [WORD_W-1:0] TO_JTAG = 16'hE73C
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic swdMode,
  output logic modeChange,
  output logic lineReset
);
  dpStrobes_t        strobes;
  logic              runHit;
  logic              wordFull;
  logic [WORD_W-1:0] nextWord;

  swjLineDatapath #(
    .RUN_MIN(RUN_MIN), .CNT_W(CNT_W), .WORD_W(WORD_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strobes(strobes),
    .runHit(runHit), .wordFull(wordFull), .nextWord(nextWord)
  );

  swjModeControl #(
    .WORD_W(WORD_W), .TO_SWD(TO_SWD), .TO_JTAG(TO_JTAG)
  ) i_control (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .runHit(runHit),
    .wordFull(wordFull), .nextWord(nextWord), .strobes(strobes),
    .swdMode(swdMode), .modeChange(modeChange), .lineReset(lineReset)
  );
endmodule

// File: tb/test_swjModeSelect.sv
module test_swjModeSelect;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // stimulus table: high-run length, word, expected mode, expected pulse
  localparam int          RUNS [NVEC] = '{50, 50, 49, 60, 55, 100, 50, 70};
  localparam logic [15:0] WORDS[NVEC] = '{16'hE79E, 16'hE79E, 16'hE73C, 16'hE73C,
                                          16'h1234, 16'hE79E, 16'hE79C, 16'hE73C};
  localparam bit          MODES[NVEC] = '{1, 1, 1, 0, 0, 1, 1, 0};
  localparam bit          CHGS [NVEC] = '{1, 0, 0, 1, 0, 1, 0, 1};
  // tags: R2, R9, R3, R4, R5, R10, R5, R4

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic swdMode, modeChange, lineReset;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  swjModeSelect i_swjModeSelect (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .swdMode(swdMode), .modeChange(modeChange), .lineReset(lineReset)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // drive at a falling edge; return at the next falling edge (sample taken)
  task automatic sendBit(input logic b);
    lineIn = b;
    @(negedge clk);
  endtask

  task automatic sendRun(input int n);
    sendBit(1'b0);
    repeat (n) sendBit(1'b1);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 0; i < 16; i++) sendBit(w[i]);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(swdMode, 1'b0, "R1 mode in reset");
    check(modeChange, 1'b0, "R1 pulse in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(swdMode, 1'b0, "R1 mode after reset");
    check(lineReset, 1'b0, "R1 line reset after reset");

    for (int v = 0; v < NVEC; v++) begin
      sendRun(RUNS[v]);
      sendWord(WORDS[v]);
      check(swdMode, MODES[v], $sformatf("table %0d mode", v));
      check(modeChange, CHGS[v], $sformatf("table %0d pulse", v));
    end

    // R7 no line reset in JTAG mode
    sendRun(50);
    check(lineReset, 1'b0, "R7 JTAG run");
    sendWord(16'hE79E);
    check(modeChange, 1'b1, "R2 pulse");
    sendBit(1'b0);
    check(modeChange, 1'b0, "R9 pulse one cycle");
    check(swdMode, 1'b1, "R2 mode");

    // R6 line reset at the 50th high sample only
    sendRun(49);
    check(lineReset, 1'b0, "R6 after 49");
    sendBit(1'b1);
    check(lineReset, 1'b1, "R6 after 50");
    check(swdMode, 1'b1, "R6 mode kept");
    sendBit(1'b1);
    check(lineReset, 1'b0, "R6 one cycle");
    for (int i = 0; i < 80; i++) begin
      sendBit(1'b1);
      if (lineReset !== 1'b0) check(lineReset, 1'b0, "R10 saturated run");
    end
    check(lineReset, 1'b0, "R10 no repeat pulse");

    // R5 mismatch closes the window
    sendWord(16'h0000);
    check(modeChange, 1'b0, "R5 mismatch pulse");
    sendWord(16'hE73C);
    check(swdMode, 1'b1, "R5 word without run");

    // R8 broken run does not arm
    sendBit(1'b0);
    repeat (30) sendBit(1'b1);
    sendBit(1'b0);
    repeat (30) sendBit(1'b1);
    sendWord(16'hE73C);
    check(swdMode, 1'b1, "R8 broken run mode");
    check(modeChange, 1'b0, "R8 broken run pulse");

    // R1 asynchronous reset mid-operation
    #2 rstN = 1'b0;
    #1 check(swdMode, 1'b0, "R1 async reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(modeChange, 1'b0, "R1 pulse after async reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule